// File: doc/BRIEF.md
# UART Transmit and Receive Queue Pair

This block sits between a UART's bus-facing data port and its serializer and deserializer. It holds two independent queues. The transmit queue takes 8-bit characters written by the bus and hands them to the serializer one pop at a time. The receive queue takes characters from the deserializer together with three per-character error flags. The bus reads each of these as a 12-bit word that also carries the current receive overrun flag.

A runtime control selects the depth of both queues. When the control is low, each queue is a one-entry holding register. When it is high, each queue is a 16-entry first-in first-out buffer. Any change of the control empties both queues. Each queue reports empty and full. A receive character that arrives when the receive queue is full is dropped and raises a sticky overrun flag, which stays set until it is cleared explicitly.

Both queue heads are shown ahead of the pop: `tx_data` and `bus_rdata` always present the oldest stored entry. The matching pop or read strobe removes that entry at the next clock edge.

Top module: `uart_queue_pair`

## Requirements
- R1: After a synchronous reset, both queues are empty, neither is full, the overrun flag is 0, and holding-register mode (depth 1) is selected.
- R2: With `fifo_en` high, each queue stores up to 16 entries and returns them in arrival order. Full asserts exactly when 16 entries are stored.
- R3: With `fifo_en` low, each queue holds one entry. Full asserts in the cycle after one entry is accepted, and empty asserts in the cycle after that entry is consumed.
- R4: A `bus_wr` while the transmit queue is full is ignored. Stored entries, `tx_data` and `tx_full` stay unchanged.
- R5: An `rx_push` while the receive queue is full drops the new character and sets `rx_overrun` on the next edge. `rx_overrun` stays set until an `ovr_clr` cycle with no overflowing push. When both happen in the same cycle, setting wins.
- R6: `bus_rdata` is laid out as follows. Bits [7:0] are the data. Bit 8 is framing error, bit 9 is parity error and bit 10 is break, taken from `rx_perr` bits 0, 1 and 2 at push time. Bit 11 is the current value of `rx_overrun`.
- R7: In a cycle where `fifo_en` differs from the mode in force, both queues are emptied at the next edge and the new mode takes effect. Pushes, pops and reads in that cycle have no effect on the queues. The overrun flag keeps its value.
- R8: A `tx_pop` or `bus_rd` on an empty queue has no effect. While a queue is empty, its data output shows zero in its data and error bit positions.
- R9: A push and a pop in the same cycle are both honoured when the queue is neither empty nor full. A push into a full queue is rejected even if a pop occurs in the same cycle. A pop on an empty queue is ignored while a push in the same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects 16-entry mode, 0 selects holding-register mode |
| bus_wr | input | 1 | Bus write strobe into the transmit queue |
| bus_wdata | input | 8 | Character written by the bus |
| bus_rd | input | 1 | Bus read strobe, pops the receive head |
| bus_rdata | output | 12 | Receive head word: data, error flags, overrun |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| tx_pop | input | 1 | Serializer takes the transmit head |
| tx_data | output | 8 | Transmit head character |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_push | input | 1 | Deserializer delivers a character |
| rx_pdata | input | 8 | Received character |
| rx_perr | input | 3 | Error flags: bit0 framing, bit1 parity, bit2 break |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The hardest situations to reach from the ports are those where several rules meet in one cycle. Examples are a push and a pop against a completely full 16-entry queue, an overrun that coincides with a clear, and a mode change that coincides with traffic. The directed stimulus first fills each queue to exactly its limit in both modes and then issues these collisions on purpose. A long random phase follows, with dense strobes and occasional mode toggles, so that fill levels sweep across full and empty repeatedly. A behavioural queue model is compared with every output on every cycle.

// File: rtl/uq_pkg.sv
package uq_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;
    localparam int WORD_W = DATA_W + ERR_W + 1;

    // Per-character error flags; packed so that frm is bit 0.
    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rx_err_t;

    typedef struct packed {
        rx_err_t           err;
        logic [DATA_W-1:0] data;
    } rx_slot_t;

    typedef struct packed {
        logic              ovr;
        rx_err_t           err;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    function automatic rx_word_t make_word(input logic ovr, input rx_slot_t s);
        rx_word_t w;
        w.ovr  = ovr;
        w.err  = s.err;
        w.data = s.data;
        return w;
    endfunction

endpackage

// File: rtl/uq_ring.sv
module uq_ring #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         one_deep,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [DEPTH-1:0] slot_we;
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt, cap;
    logic             push_ok, pop_ok;

    assign cap     = one_deep ? CW'(1) : CW'(DEPTH);
    assign full    = (cnt == cap);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_we
            assign slot_we[gi] = push_ok && (wr_ptr == AW'(gi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) slots[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head = empty ? '0 : slots[rd_ptr];

endmodule

// File: rtl/uq_ovr_flag.sv
module uq_ovr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/uart_queue_pair.sv
module uart_queue_pair
    import uq_pkg::*;
#(
    parameter int QDEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              ovr_clr,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_full,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_pdata,
    input  logic [ERR_W-1:0]  rx_perr,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overrun
);
    localparam int SLOT_W = $bits(rx_slot_t);

    logic     mode_q;
    logic     mode_chg;
    rx_slot_t rx_in;
    rx_slot_t rx_head;

    assign mode_chg = (fifo_en != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_en;
    end

    assign rx_in.err  = rx_err_t'(rx_perr);
    assign rx_in.data = rx_pdata;

    uq_ring #(.W(DATA_W), .DEPTH(QDEPTH)) tx_ring_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (mode_chg),
        .one_deep  (!mode_q),
        .push      (bus_wr),
        .push_data (bus_wdata),
        .pop       (tx_pop),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uq_ring #(.W(SLOT_W), .DEPTH(QDEPTH)) rx_ring_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (mode_chg),
        .one_deep  (!mode_q),
        .push      (rx_push),
        .push_data (rx_in),
        .pop       (bus_rd),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    uq_ovr_flag ovr_i (
        .clk  (clk),
        .rst  (rst),
        .set  (rx_push && rx_full),
        .clr  (ovr_clr),
        .flag (rx_overrun)
    );

    assign bus_rdata = make_word(rx_overrun, rx_head);

endmodule

// File: rtl/uart_queue_pair_chk.sv
module uart_queue_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_en,
    input logic       mode_q,
    input logic       bus_wr,
    input logic       tx_pop,
    input logic [7:0] tx_data,
    input logic       tx_empty,
    input logic       tx_full,
    input logic       rx_push,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       rx_overrun,
    input logic       ovr_clr
);
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> rx_overrun); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !ovr_clr) |=> rx_overrun); // R5

    AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_pop && (fifo_en == mode_q)) |=> (tx_full && $stable(tx_data))); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != mode_q) |=> (tx_empty && rx_empty)); // R7

    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !fifo_en && tx_empty && bus_wr) |=> tx_full); // R3

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !bus_wr && (fifo_en == mode_q)) |=> tx_empty); // R8
endmodule

bind uart_queue_pair uart_queue_pair_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .mode_q     (mode_q),
    .bus_wr     (bus_wr),
    .tx_pop     (tx_pop),
    .tx_data    (tx_data),
    .tx_empty   (tx_empty),
    .tx_full    (tx_full),
    .rx_push    (rx_push),
    .rx_empty   (rx_empty),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .ovr_clr    (ovr_clr)
);

// File: tb/uart_queue_pair_tb_top.sv
module uart_queue_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst, fifo_en, bus_wr, bus_rd, ovr_clr, tx_pop, rx_push;
    logic [7:0]  bus_wdata, rx_pdata, tx_data;
    logic [2:0]  rx_perr;
    logic [11:0] bus_rdata;
    logic        tx_empty, tx_full, rx_empty, rx_full, rx_overrun;

    always #10 clk = ~clk;

    uart_queue_pair dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ovr_clr(ovr_clr), .tx_pop(tx_pop),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_full(tx_full), .rx_push(rx_push),
        .rx_pdata(rx_pdata), .rx_perr(rx_perr), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_overrun(rx_overrun)
    );

    // Behavioural reference
    bit          m_mode;
    bit          m_ovr;
    logic [7:0]  m_tx[$];
    logic [10:0] m_rx[$];
    int          checks = 0;
    int          errors = 0;
    string       req = "R1";
    bit          done = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int cap = m_mode ? 16 : 1;
        chk("tx_empty", 32'(tx_empty), 32'(m_tx.size() == 0));
        chk("tx_full",  32'(tx_full),  32'(m_tx.size() == cap));
        chk("tx_data",  32'(tx_data),  (m_tx.size() != 0) ? 32'(m_tx[0]) : 32'd0);
        chk("rx_empty", 32'(rx_empty), 32'(m_rx.size() == 0));
        chk("rx_full",  32'(rx_full),  32'(m_rx.size() == cap));
        chk("rx_overrun", 32'(rx_overrun), 32'(m_ovr));
        chk("bus_rdata", 32'(bus_rdata),
            32'({m_ovr, (m_rx.size() != 0) ? m_rx[0] : 11'd0}));
    endtask

    task automatic model_update();
        int  cap    = m_mode ? 16 : 1;
        bit  rxfull = (m_rx.size() == cap);
        bit  txok, rxok;
        if (rst) begin
            m_mode = 0; m_ovr = 0; m_tx.delete(); m_rx.delete();
            return;
        end
        if (rx_push && rxfull) m_ovr = 1;
        else if (ovr_clr)      m_ovr = 0;
        if (fifo_en != m_mode) begin
            m_mode = fifo_en; m_tx.delete(); m_rx.delete();
            return;
        end
        txok = bus_wr && (m_tx.size() < cap);
        rxok = rx_push && !rxfull;
        if (tx_pop && m_tx.size() > 0) void'(m_tx.pop_front());
        if (bus_rd && m_rx.size() > 0) void'(m_rx.pop_front());
        if (txok) m_tx.push_back(bus_wdata);
        if (rxok) m_rx.push_back({rx_perr, rx_pdata});
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; ovr_clr = 0; tx_pop = 0; rx_push = 0;
        bus_wdata = '0; rx_pdata = '0; rx_perr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic wr(logic [7:0] d);   bus_wr = 1; bus_wdata = d; endtask
    task automatic rxp(logic [7:0] d, logic [2:0] e); rx_push = 1; rx_pdata = d; rx_perr = e; endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(); fifo_en = 0; rst = 1;
        tick(); tick();
        rst = 0;
        req = "R1"; tick();

        // empty pops ignored
        req = "R8"; tx_pop = 1; bus_rd = 1; tick(); tick();

        // holding-register mode
        req = "R3"; wr(8'hA5); tick();
        req = "R4"; wr(8'h3C); tick();
        req = "R3"; tx_pop = 1; tick(); tick();
        req = "R6"; rxp(8'h5A, 3'b101); tick();
        req = "R5"; rxp(8'h11, 3'b010); tick();
        req = "R5"; tick();
        req = "R6"; bus_rd = 1; tick();
        req = "R5"; ovr_clr = 1; tick();
        req = "R8"; bus_rd = 1; tx_pop = 1; wr(8'h77); tick(); // R9 pop on empty, push taken
        req = "R9"; tx_pop = 1; wr(8'h88); tick(); // full: pop taken, push rejected

        // mode switch flushes, traffic in that cycle ignored
        req = "R7"; rxp(8'h42, 3'b000); tick();
        req = "R7"; fifo_en = 1; wr(8'h99); rxp(8'h01, 3'b001); tick();

        // fill to 16 and past
        req = "R2";
        for (int i = 0; i < 18; i++) begin
            if (i >= 16) req = "R4";
            wr(8'(i * 7 + 3)); rxp(8'(i + 100), 3'(i)); tick();
        end
        req = "R5"; ovr_clr = 1; rxp(8'hEE, 3'b111); tick(); // set wins
        req = "R9"; tx_pop = 1; wr(8'hF0); bus_rd = 1; rxp(8'hF1, 3'b000); tick();
        req = "R9"; tx_pop = 1; wr(8'hF2); bus_rd = 1; rxp(8'hF3, 3'b011); tick();
        req = "R2";
        for (int i = 0; i < 18; i++) begin tx_pop = 1; bus_rd = 1; tick(); end

        // error flag layout
        req = "R6";
        ovr_clr = 1; tick();
        for (int e = 0; e < 8; e++) begin rxp(8'(8'hC0 + e), 3'(e)); tick(); end
        for (int e = 0; e < 8; e++) begin bus_rd = 1; tick(); end

        // switch back to holding mode with data stored
        req = "R7"; wr(8'h12); rxp(8'h34, 3'b100); tick();
        fifo_en = 0; tick(); tick();

        // random traffic
        req = "R9";
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 200) == 0) fifo_en = ~fifo_en;
            bus_wr  = ($urandom % 3) != 0; bus_wdata = 8'($urandom);
            tx_pop  = ($urandom % 3) == 0;
            rx_push = ($urandom % 2) != 0; rx_pdata = 8'($urandom); rx_perr = 3'($urandom);
            bus_rd  = ($urandom % 3) == 0;
            ovr_clr = ($urandom % 16) == 0;
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule